// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between a CPU with a 16-bit memory address and a 2 MB byte-wide physical memory. It turns every CPU memory address into a 21-bit physical address. The upper 32 KB of CPU space (A15 = 1) always lands in the topmost 32 KB physical block, at physical 0x1F8000 through 0x1FFFFF. The lower 32 KB of CPU space (A15 = 0) lands in whichever 32 KB physical block a bank register names.

Software loads the bank register with a CPU I/O write to port 0x1F. Only the low byte of the I/O port address is decoded. The register can only be written. Reset loads it with all ones. Straight after reset, both halves of the CPU space therefore see the same top physical block.

The translation path is purely combinational. The bank register is the only state. Reset is synchronous and active-high.

Top module: `bank_addr_mapper`

## Requirements
- R1: When cpu_addr[15] is 1, phys_addr equals 0x1F8000 + cpu_addr[14:0], whatever the bank register holds.
- R2: When cpu_addr[15] is 0, phys_addr equals bank*0x8000 + cpu_addr[14:0], where bank is the 6-bit value held in the bank register. Bank 0 is the lowest block and bank 0x3F is the top block.
- R3: After a rising clock edge with rst high, the bank register holds 0x3F. The lower half then aliases the top block, so cpu_addr 0x1234 maps to 0x1F9234.
- R4: The bank register loads io_wdata[5:0] at a rising edge where io_wr is 1 and io_port[7:0] is 0x1F. io_wdata[7:6] are ignored.
- R5: io_port[15:8] play no part in the decode, so port 0xAB1F loads the register just as port 0x001F does.
- R6: An I/O write to any port whose low byte is not 0x1F leaves the bank register unchanged.
- R7: While io_wr is 0, changes on io_port and io_wdata leave the bank register unchanged.
- R8: A memory address sampled in the same cycle as a bank write still maps through the old bank. The new bank applies from the cycle after the loading edge.
- R9: When rst and a bank write arrive at the same edge, reset wins and the register holds 0x3F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU memory address |
| io_wr | input | 1 | CPU I/O write strobe, sampled at the rising edge |
| io_port | input | 16 | CPU I/O port address |
| io_wdata | input | 8 | CPU data bus during I/O writes |
| phys_addr | output | 21 | Translated physical memory address |

## Verification
phys_addr is a combinational function of cpu_addr and the bank register, so it is due in the same cycle that cpu_addr changes. A bank write becomes visible one rising edge later. The bench drives inputs on the falling edge and samples phys_addr one time unit afterwards, always before the next rising edge. It advances its bank model only after that rising edge, so a check taken in the write cycle expects the old bank (R8) and the check taken in the next cycle expects the new one.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    // Memory geometry
    localparam int CPU_AW  = 16;
    localparam int PHYS_AW = 21;
    localparam int OFF_AW  = CPU_AW - 1;          // offset inside a 32 KB window
    localparam int BLK_AW  = PHYS_AW - OFF_AW;    // 32 KB block index width

    // I/O geometry
    localparam int PORT_AW = 16;
    localparam int DEC_AW  = 8;                   // decoded low part of the port
    localparam int DATA_W  = 8;

    localparam logic [DEC_AW-1:0] BANK_PORT = 8'h1F;
    localparam logic [BLK_AW-1:0] TOP_BLK   = '1;
    localparam logic [BLK_AW-1:0] BANK_RST  = TOP_BLK;

    typedef logic [BLK_AW-1:0] blk_t;
    typedef logic [OFF_AW-1:0] off_t;

    typedef struct packed {
        blk_t blk;
        off_t off;
    } phys_t;

    typedef struct packed {
        logic hi;    // selects the fixed upper window
        off_t off;
    } cpu_addr_t;

    function automatic logic port_hit(input logic [PORT_AW-1:0] port);
        return port[DEC_AW-1:0] == BANK_PORT;
    endfunction

    function automatic phys_t compose(input cpu_addr_t a, input blk_t bank);
        phys_t p;
        p.blk = a.hi ? TOP_BLK : bank;
        p.off = a.off;
        return p;
    endfunction

endpackage

// File: rtl/bank_port_decode.sv
module bank_port_decode
    import bank_map_pkg::*;
(
    input  logic               io_wr,
    input  logic [PORT_AW-1:0] io_port,
    output logic               load
);
    logic unused_port_hi;
    assign unused_port_hi = &{1'b0, io_port[PORT_AW-1:DEC_AW]};

    assign load = io_wr && port_hit(io_port);
endmodule

// File: rtl/bank_select_reg.sv
module bank_select_reg
    import bank_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output blk_t              bank_q
);
    logic unused_data_hi;
    assign unused_data_hi = &{1'b0, wdata[DATA_W-1:BLK_AW]};

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= BANK_RST;
        else if (load)
            bank_q <= wdata[BLK_AW-1:0];
    end

    // R3, R9: reset value, with priority over a write at the same edge
    a_r3_reset_value: assert property (@(posedge clk)
        rst |=> bank_q == BANK_RST);

    a_r4_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> bank_q == $past(wdata[BLK_AW-1:0]));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(bank_q));
endmodule

// File: rtl/bank_addr_compose.sv
module bank_addr_compose
    import bank_map_pkg::*;
(
    input  cpu_addr_t a,
    input  blk_t      bank,
    output phys_t     p
);
    assign p = compose(a, bank);
endmodule

// File: rtl/bank_addr_mapper.sv
module bank_addr_mapper
    import bank_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               io_wr,
    input  logic [PORT_AW-1:0] io_port,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [PHYS_AW-1:0] phys_addr
);
    logic  load;
    blk_t  bank_q;
    phys_t phys;

    bank_port_decode u_dec (
        .io_wr   (io_wr),
        .io_port (io_port),
        .load    (load)
    );

    bank_select_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .wdata  (io_wdata),
        .bank_q (bank_q)
    );

    bank_addr_compose u_cmp (
        .a    (cpu_addr_t'(cpu_addr)),
        .bank (bank_q),
        .p    (phys)
    );

    assign phys_addr = phys;

    a_r1_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[CPU_AW-1] |-> phys_addr[PHYS_AW-1:OFF_AW] == TOP_BLK);

    a_r2_lower_banked: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[CPU_AW-1] |-> phys_addr[PHYS_AW-1:OFF_AW] == bank_q);

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFF_AW-1:0] == cpu_addr[OFF_AW-1:0]);

    a_r6_foreign_port: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_port[DEC_AW-1:0] != BANK_PORT) |=> $stable(bank_q));
endmodule

// File: tb/tb_bank_addr_mapper.sv
module tb_bank_addr_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        io_wr;
    logic [15:0] io_port;
    logic [7:0]  io_wdata;
    logic [20:0] phys_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int model_bank;

    bank_addr_mapper dut (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .io_wr     (io_wr),
        .io_port   (io_port),
        .io_wdata  (io_wdata),
        .phys_addr (phys_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_phys(input int addr, input int bank);
        if (addr >= 32'h8000)
            return 32'h1F8000 + (addr % 32'h8000);
        return bank * 32'h8000 + (addr % 32'h8000);
    endfunction

    // Drive one cycle, check the translation before the edge, then advance the model.
    task automatic step(input int addr, input bit wr, input int port,
                        input int data, input bit r, input string tag);
        int exp;
        @(negedge clk);
        cpu_addr = addr[15:0];
        io_wr    = wr;
        io_port  = port[15:0];
        io_wdata = data[7:0];
        rst      = r;
        #1;
        if (!r) begin
            exp = exp_phys(addr, model_bank);
            n_checks++;
            if (int'(phys_addr) != exp) begin
                n_fail++;
                $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr[15:0], phys_addr, exp);
            end
        end
        @(posedge clk);
        if (r)
            model_bank = 63;
        else if (wr && (port % 256) == 32'h1F)
            model_bank = data % 64;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED_0017;
        void'($urandom(seed));
        model_bank = 63;
        rst = 1'b1; cpu_addr = '0; io_wr = 1'b0; io_port = '0; io_wdata = '0;
        step(0, 0, 0, 0, 1, "R3");
        step(0, 0, 0, 0, 1, "R3");

        // R3: reset value aliases the lower half onto the top block
        step(16'h1234, 0, 0, 0, 0, "R3");
        step(16'h9234, 0, 0, 0, 0, "R1");

        // R4: load bank 0, then boundary offsets
        step(16'h8000, 1, 16'h001F, 8'h00, 0, "R1");
        step(16'h0000, 0, 0, 0, 0, "R2");
        step(16'h7FFF, 0, 0, 0, 0, "R2");
        step(16'hFFFF, 0, 0, 0, 0, "R1");

        // R4: upper data bits ignored (0xC5 -> bank 5)
        step(16'h0000, 1, 16'h001F, 8'hC5, 0, "R4");
        step(16'h0ABC, 0, 0, 0, 0, "R4");

        // R5: upper port byte ignored
        step(16'h0000, 1, 16'hAB1F, 8'h0A, 0, "R5");
        step(16'h0010, 0, 0, 0, 0, "R5");

        // R6: other ports ignored
        step(16'h0000, 1, 16'h001E, 8'h22, 0, "R6");
        step(16'h0000, 1, 16'h009F, 8'h23, 0, "R6");
        step(16'h0000, 1, 16'h1F00, 8'h24, 0, "R6");
        step(16'h0020, 0, 0, 0, 0, "R6");

        // R7: no strobe, matching port and data wiggle
        step(16'h0000, 0, 16'h001F, 8'h11, 0, "R7");
        step(16'h0030, 0, 16'h001F, 8'h12, 0, "R7");

        // R8: same-cycle address uses old bank, next cycle the new one
        step(16'h0100, 1, 16'h001F, 8'h09, 0, "R8");
        step(16'h0100, 0, 0, 0, 0, "R8");

        // R9: reset beats a simultaneous write
        step(16'h0000, 1, 16'h001F, 8'h02, 1, "R9");
        step(16'h0040, 0, 0, 0, 0, "R9");

        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int a, p, d;
            bit w;
            a = int'($urandom() % 65536);
            w = ($urandom() % 3) == 0;
            p = (($urandom() % 2) == 0) ? int'(($urandom() % 256) * 256 + 32'h1F)
                                       : int'($urandom() % 65536);
            d = int'($urandom() % 256);
            step(a, w, p, d, 0, (a >= 32'h8000) ? "R1" : "R2");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule